// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a target device has left stuck. A target that was interrupted in the middle of a read can keep SDA low while it waits for more clock. A one-cycle start request makes the block take both lines as open-drain drivers. It holds SCL low and lets SDA float, then clocks SCL, one pulse at a time, for as long as the synchronised SDA input still reads low. Pulsing stops as soon as SDA is seen high, or when a fixed pulse limit is reached. The block then drives a STOP condition: SDA is pulled low while SCL is low, SCL is released, and after a half period SDA is released, so that SDA rises while SCL is high.

All timing is counted in system clock cycles. One parameter sets the length of an SCL half period, and its default gives standard-mode 100 kHz from a 50 MHz clock. A second parameter sets the pulse limit, which defaults to 9. The block reports busy while the sequence runs and pulses done once at the end. A status bit records whether SDA came free before the limit ran out.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, and whenever busy is low, scl_oe, sda_oe and done are 0. sda_released is 0 after reset. An output value of 1 pulls its line low, and 0 releases it.
- R2: A start seen while idle raises busy on the next clock. From that clock scl_oe is 1 and sda_oe is 0 for exactly CLKS_PER_HALF cycles before the first SDA test.
- R3: Every timed phase lasts exactly CLKS_PER_HALF cycles: the initial hold, each SCL high phase, each SCL low phase, the STOP setup and the STOP high phase. Each pulse is one high phase (scl_oe 0) followed by one low phase (scl_oe 1).
- R4: SDA is tested at the end of the initial hold and at the end of each low phase, through a two-flop synchroniser. When the test sees SDA high, pulsing stops. The pulse count then equals the number of pulses the target needed before it let go of SDA, and is 0 if SDA was already high.
- R5: No more than MAX_PULSES (default 9) SCL pulses are issued. After the last one the STOP is generated even if SDA is still low.
- R6: STOP setup: sda_oe rises only while scl_oe is 1, and both stay 1 for CLKS_PER_HALF cycles.
- R7: STOP: scl_oe then goes to 0 with sda_oe still 1 for CLKS_PER_HALF cycles. sda_oe then falls while scl_oe is 0.
- R8: done is high for exactly one cycle per sequence, on the last busy cycle. busy lasts (3 + 2·pulses)·CLKS_PER_HALF + 1 cycles.
- R9: sda_released is cleared when a sequence starts. At the final SDA test it is set to 1 if SDA read high and to 0 if the pulse limit ended the loop. It then holds its value until the next start.
- R10: A start asserted while busy is high is ignored. The running sequence keeps its pulse count and length, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a recovery sequence (sampled when idle) |
| sda_in | input | 1 | SDA line level read back from the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on the final cycle of a sequence |
| sda_released | output | 1 | SDA was seen high before the pulse limit ended the loop |

## Verification
The bench models a target that keeps SDA low for a chosen number of SCL pulses and lets go on the falling SCL edge that follows the last of them. The number is drawn at random across the whole range and also set directly to 0, 1, the limit, one past the limit and far past it. At the limit boundary, a design with an off-by-one in its loop test would issue ten pulses or eight, and would report the wrong status when the target frees SDA exactly on the ninth pulse. A design that tests SDA before the synchroniser has settled, or that shortens a phase, shows up as a run length other than CLKS_PER_HALF or as a busy length that does not match the pulse count. Some runs repeat start in the middle of a sequence: a design that restarts, or that queues the request, changes the busy length or raises busy again after done. A design that ordered the STOP edges wrongly would release SDA while SCL is low, which the bench flags.

// File: rtl/i2c_recover_pkg.sv
package i2c_recover_pkg;

  typedef enum logic [2:0] {
    RS_IDLE   = 3'd0,
    RS_PREP   = 3'd1,
    RS_HIGH   = 3'd2,
    RS_LOW    = 3'd3,
    RS_SETUP  = 3'd4,
    RS_STOPHI = 3'd5,
    RS_DONE   = 3'd6
  } recov_state_t;

  // Busy length of one sequence: hold, two phases per pulse, setup,
  // stop high, plus the single done cycle.
  function automatic int unsigned seq_busy_cycles(input int unsigned pulses,
                                                  input int unsigned half);
    return (3 + 2 * pulses) * half + 1;
  endfunction

  // Line drive for each state: SCL pulled low in the hold, low and setup phases.
  function automatic logic scl_pull(input recov_state_t s);
    return (s == RS_PREP) || (s == RS_LOW) || (s == RS_SETUP);
  endfunction

  // SDA pulled low from STOP setup until the rising STOP edge.
  function automatic logic sda_pull(input recov_state_t s);
    return (s == RS_SETUP) || (s == RS_STOPHI);
  endfunction

endpackage

// File: rtl/recov_sync2.sv
module recov_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/recov_half_timer.sv
module recov_half_timer #(
  parameter int unsigned CLKS_PER_HALF = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int unsigned TW = (CLKS_PER_HALF > 1) ? $clog2(CLKS_PER_HALF) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(CLKS_PER_HALF - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import i2c_recover_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sda_hi,
  input  logic          half_expire,
  output logic          tmr_load,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          sda_released,
  output logic [PW-1:0] pulse_cnt,
  output logic          loop_test,
  output logic          loop_exit
);
  recov_state_t  state_q, state_nx;
  logic [PW-1:0] pcnt_q;
  logic          rel_q;
  logic          scl_q, sda_q;
  logic          accept;
  logic          at_limit;

  assign accept    = (state_q == RS_IDLE) && start;
  assign at_limit  = (pcnt_q == PW'(MAX_PULSES));
  assign loop_test = half_expire && ((state_q == RS_PREP) || (state_q == RS_LOW));
  assign loop_exit = loop_test && (sda_hi || at_limit);

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      RS_IDLE:   if (start) state_nx = RS_PREP;
      RS_PREP,
      RS_LOW:    if (half_expire) state_nx = loop_exit ? RS_SETUP : RS_HIGH;
      RS_HIGH:   if (half_expire) state_nx = RS_LOW;
      RS_SETUP:  if (half_expire) state_nx = RS_STOPHI;
      RS_STOPHI: if (half_expire) state_nx = RS_DONE;
      RS_DONE:   state_nx = RS_IDLE;
      default:   state_nx = RS_IDLE;
    endcase
  end

  assign tmr_load = (state_nx != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      pcnt_q  <= '0;
      rel_q   <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      scl_q   <= scl_pull(state_nx);
      sda_q   <= sda_pull(state_nx);
      if (accept) begin
        pcnt_q <= '0;
        rel_q  <= 1'b0;
      end else if (loop_exit) begin
        rel_q  <= sda_hi;
      end else if (loop_test) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign scl_oe       = scl_q;
  assign sda_oe       = sda_q;
  assign busy         = (state_q != RS_IDLE);
  assign done         = (state_q == RS_DONE);
  assign sda_released = rel_q;
  assign pulse_cnt    = pcnt_q;
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int unsigned CLKS_PER_HALF = 250,
  parameter int unsigned MAX_PULSES    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic sda_released
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);

  // Named internal events, brought out for the checker.
  logic          sda_hi;
  logic          half_expire;
  logic          tmr_load;
  logic          loop_test;
  logic          loop_exit;
  logic [PW-1:0] pulse_cnt;

  recov_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_hi)
  );

  recov_half_timer #(.CLKS_PER_HALF(CLKS_PER_HALF)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .expire (half_expire)
  );

  recov_ctrl #(.MAX_PULSES(MAX_PULSES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sda_hi       (sda_hi),
    .half_expire  (half_expire),
    .tmr_load     (tmr_load),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .busy         (busy),
    .done         (done),
    .sda_released (sda_released),
    .pulse_cnt    (pulse_cnt),
    .loop_test    (loop_test),
    .loop_exit    (loop_exit)
  );
endmodule

// File: rtl/recov_chk.sv
module recov_chk #(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          busy,
  input logic          done,
  input logic          sda_released,
  input logic [PW-1:0] pulse_cnt,
  input logic          loop_exit
);
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe && !done));

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && scl_oe && !sda_oe));

  // R5
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pulse_cnt <= PW'(MAX_PULSES)));

  // R6
  stop_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe);

  // R7
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sda_released);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_exit && !(start && !busy)) |=> $stable(sda_released));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy && (pulse_cnt >= $past(pulse_cnt))));
endmodule

bind i2c_bus_recover recov_chk #(.MAX_PULSES(MAX_PULSES)) u_recov_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .scl_oe       (scl_oe),
  .sda_oe       (sda_oe),
  .busy         (busy),
  .done         (done),
  .sda_released (sda_released),
  .pulse_cnt    (pulse_cnt),
  .loop_exit    (loop_exit)
);

// File: tb/test_i2c_bus_recover.sv
module test_i2c_bus_recover;
  localparam int H    = 6;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sda_in;
  logic scl_oe, sda_oe, busy, done, sda_released;

  always #10 clk = ~clk;

  i2c_bus_recover #(.CLKS_PER_HALF(H), .MAX_PULSES(MAXP)) i_i2c_bus_recover (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .sda_released(sda_released)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // Target model: holds SDA low for n_hold pulses, lets go when SCL falls after the last.
  int   n_hold  = 0;
  int   seen    = 0;
  bit   running = 0;
  logic slave_low;
  always_comb slave_low = running && ((seen < n_hold) || (seen == n_hold && n_hold > 0 && !scl_oe));
  assign sda_in = !(sda_oe || slave_low);

  // Monitor, sampled on the falling edge.
  int busy_len, done_cnt, pulses_mon, bad_runs, runlen, setup_len, stophi_len, bad_stop, prep_len;
  bit got_rel;
  logic p_scl = 0, p_sda = 0, p_busy = 0, p_done = 0;

  always @(negedge clk) begin
    if (running && p_scl && !scl_oe && !sda_oe) seen++;
    if (busy) busy_len++;
    if (done) done_cnt++;
    if (busy && p_scl && !scl_oe && !sda_oe) begin pulses_mon++; got_rel = 1; end
    if (busy && !done && scl_oe && !sda_oe && !got_rel) prep_len++;
    if (busy && !done && sda_oe && scl_oe) setup_len++;
    if (busy && !done && sda_oe && !scl_oe) stophi_len++;
    if (p_sda && !sda_oe && scl_oe) bad_stop++;
    if (busy && !done) begin
      if (p_busy && !p_done && scl_oe == p_scl && sda_oe == p_sda) runlen++;
      else begin
        if (p_busy && !p_done && runlen != H) bad_runs++;
        runlen = 1;
      end
    end else if (done && p_busy && !p_done && runlen != H) bad_runs++;
    p_scl = scl_oe; p_sda = sda_oe; p_busy = busy; p_done = done;
  end

  function automatic int exp_pulses(int n);
    return (n < MAXP) ? n : MAXP;
  endfunction

  function automatic int exp_busy(int p);
    int acc = 1;
    acc += H;            // initial hold
    acc += p * H * 2;    // pulses
    acc += 2 * H;        // stop setup + stop high
    return acc;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  task automatic run_seq(int n, bit poke);
    int ep;
    while (busy) @(negedge clk);
    busy_len = 0; done_cnt = 0; pulses_mon = 0; bad_runs = 0; runlen = 0;
    setup_len = 0; stophi_len = 0; bad_stop = 0; prep_len = 0; got_rel = 0;
    n_hold = n; seen = 0; running = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && scl_oe && !sda_oe, "R2", "launch state", int'(busy), 1);
    if (poke) begin
      repeat (2 * H) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    running = 0;
    ep = exp_pulses(n);
    if (n <= MAXP) chk(pulses_mon == ep, "R4", "pulse count", pulses_mon, ep);
    else           chk(pulses_mon == ep, "R5", "capped pulse count", pulses_mon, ep);
    chk(busy_len == exp_busy(ep), "R8", "busy length", busy_len, exp_busy(ep));
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(bad_runs == 0, "R3", "phase length errors", bad_runs, 0);
    chk(prep_len == H, "R2", "initial hold", prep_len, H);
    chk(setup_len == H, "R6", "stop setup length", setup_len, H);
    chk(stophi_len == H && bad_stop == 0, "R7", "stop high length", stophi_len, H);
    chk(sda_released == (n <= MAXP), "R9", "status", int'(sda_released), int'(n <= MAXP));
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R1", "idle lines", int'(scl_oe | sda_oe | busy), 0);
    chk(sda_released == (n <= MAXP), "R9", "status held", int'(sda_released), int'(n <= MAXP));
    if (poke) chk(!busy && done_cnt == 1, "R10", "restart ignored", done_cnt, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1C2B));
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !sda_released, "R1", "reset outputs",
        int'({scl_oe, sda_oe, busy, done, sda_released}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1", "idle after reset", int'({scl_oe, sda_oe, busy}), 0);
    // directed corners
    run_seq(0, 0);
    run_seq(1, 0);
    run_seq(MAXP - 1, 0);
    run_seq(MAXP, 0);
    run_seq(MAXP + 1, 0);
    run_seq(MAXP + 3, 1);
    run_seq(2, 1);
    // random
    for (int i = 0; i < 30; i++) begin
      int n;
      bit pk;
      n  = int'($urandom % 13);
      pk = ($urandom % 4) == 0;
      repeat (int'($urandom % 5)) @(negedge clk);
      run_seq(n, pk);
    end
    summary();
    $finish;
  end
endmodule